// File: doc/BRIEF.md
# Software Inter-Processor Interrupt Claim Controller

This block lets software on one hart interrupt another hart through a small memory-mapped register file. Every hart owns one interrupt source: hart X is reached through interrupt ID X+1. The sending hart raises the interrupt by writing a one-hot word into the pending register. Each receiving hart has a context with its own enable word and its own claim/complete register. The block drives one machine software interrupt line per hart.

The receiving hart reads its claim register. The read returns the best eligible source and clears that source's pending bit. The hart then writes the same ID back to finish the claim. Until that write arrives, the source cannot be offered to that context again. Each source has a small priority register. A priority of zero keeps the source silent.

The byte address map uses a 10-bit address. Priority registers sit at 0x000 + 4*ID. The pending word is at 0x100. The enable word of context h is at 0x200 + 4*h, and the claim/complete register of context h is at 0x300 + 4*h. In the pending and enable words, bit n stands for ID n.

Top module: `ipi_claim_ctrl`

## Requirements
- R1: After reset, every pending bit, enable bit, priority value and outstanding claim is zero, every msip output is low, and a claim read returns 0.
- R2: ID 0 does not exist. Bit 0 of the pending word and of every enable word reads 0, the priority register at 0x000 reads 0, and writes to any of them have no effect.
- R3: A write to the pending word at 0x100 sets each pending bit n for which write bit n is 1 (1 <= n <= hart count). Zero bits leave pending bits unchanged, and bits above the hart count are ignored.
- R4: msip[h] is high exactly when some source is pending, enabled in the enable word of context h, has a nonzero priority and is not claimed by context h. A priority of 0 never raises an interrupt.
- R5: The enable word of context h is at 0x200 + 4*h. It is read and written as a whole, bit n enables ID n, and each context is independent of the others.
- R6: A read of the claim register at 0x300 + 4*h returns the eligible source of context h with the highest priority; ties go to the lowest ID. The read clears that source's pending bit and marks the source as claimed by context h.
- R7: A claim read with no eligible source returns 0 and changes no pending bit or claim.
- R8: A claimed source is not presented to that context again, even if it becomes pending, until the same ID is written to that context's claim register. A completion write with any other ID is ignored.
- R9: Read data is valid with rvalid exactly one cycle after a read request. A write takes effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 32 | Read data |
| msip | output | NHART | Machine software interrupt line per hart |

## Verification
The claim logic is driven with single pending sources and with several sources pending at once. The multi-source patterns use mixed priorities, equal priorities and zero priorities, which separates the ordering by priority from the tie-break by lowest ID and from the rule that priority zero stays silent. One pattern pends a source again while its claim is still outstanding, then sends a wrong completion and then the right one. This separates the per-context claim blocking from plain pending-bit state. All-ones writes to the pending and enable words expose any bit that should be hardwired to zero or ignored. The first and the last of these cases are what R2 and R3 require.

// File: rtl/ipi_claim_ctrl.sv
module ipi_claim_ctrl #(
  parameter int NHART = 4,
  parameter int PW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [9:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic             bus_rvalid,
  output logic [31:0]      bus_rdata,
  output logic [NHART-1:0] msip
);
  localparam int NID = NHART + 1;
  localparam int IDW = $clog2(NID);

  logic [NID-1:0] pend;
  logic [PW-1:0]  prio [NID];
  logic [NID-1:0] en   [NHART];
  logic [NID-1:0] clm  [NHART];
  logic [NID-1:0] prio_nz;
  logic [NID*NHART-1:0] clm_flat;

  logic [1:0] region;
  logic [4:0] widx;
  logic       wr, rd, claim_rd, cmp_hit;
  logic [IDW-1:0] sel_id;
  logic [PW-1:0]  sel_p;
  logic [31:0]    rd_mux;

  assign region   = bus_addr[9:8];
  assign widx     = bus_addr[6:2];
  assign wr       = bus_valid && bus_write;
  assign rd       = bus_valid && !bus_write;
  assign claim_rd = rd && region == 2'd3 && int'(widx) < NHART;

  always_comb begin
    prio_nz = '0;
    for (int i = 1; i < NID; i++) prio_nz[i] = prio[i] != '0;
  end

  for (genvar h = 0; h < NHART; h++) begin : g_hart
    assign msip[h] = |(pend & en[h] & prio_nz & ~clm[h]);
    assign clm_flat[h*NID +: NID] = clm[h];
  end

  always_comb begin
    logic [NID-1:0] cand;
    cand   = '0;
    sel_id = '0;
    sel_p  = '0;
    for (int h = 0; h < NHART; h++)
      if (int'(widx) == h) cand = pend & en[h] & ~clm[h];
    for (int i = 1; i < NID; i++)
      if (cand[i] && prio[i] > sel_p) begin
        sel_p  = prio[i];
        sel_id = IDW'(i);
      end
  end

  always_comb begin
    cmp_hit = 1'b0;
    if (wr && region == 2'd3 && bus_wdata != 0 && bus_wdata < NID)
      for (int h = 0; h < NHART; h++)
        if (int'(widx) == h && clm[h][bus_wdata[IDW-1:0]]) cmp_hit = 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    case (region)
      2'd0: for (int i = 1; i < NID; i++)
              if (!bus_addr[7] && int'(widx) == i) rd_mux = 32'(prio[i]);
      2'd1: if (bus_addr[7:2] == '0) rd_mux = 32'(pend);
      2'd2: for (int h = 0; h < NHART; h++)
              if (int'(widx) == h && !bus_addr[7]) rd_mux = 32'(en[h]);
      default: if (claim_rd && !bus_addr[7]) rd_mux = 32'(sel_id);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      pend       <= '0;
      for (int i = 0; i < NID; i++) prio[i] <= '0;
      for (int h = 0; h < NHART; h++) begin
        en[h]  <= '0;
        clm[h] <= '0;
      end
    end else begin
      bus_rvalid <= rd;
      bus_rdata  <= rd ? rd_mux : '0;
      if (wr) begin
        case (region)
          2'd0: for (int i = 1; i < NID; i++)
                  if (!bus_addr[7] && int'(widx) == i) prio[i] <= bus_wdata[PW-1:0];
          2'd1: if (bus_addr[7:2] == '0)
                  pend <= pend | (bus_wdata[NID-1:0] & ~NID'(1));
          2'd2: for (int h = 0; h < NHART; h++)
                  if (int'(widx) == h && !bus_addr[7])
                    en[h] <= bus_wdata[NID-1:0] & ~NID'(1);
          default: for (int h = 0; h < NHART; h++)
                  if (cmp_hit && int'(widx) == h) clm[h][bus_wdata[IDW-1:0]] <= 1'b0;
        endcase
      end
      if (claim_rd && !bus_addr[7] && sel_id != '0) begin
        pend[sel_id] <= 1'b0;
        for (int h = 0; h < NHART; h++)
          if (int'(widx) == h) clm[h][sel_id] <= 1'b1;
      end
    end
  end

  logic claim_hit;
  assign claim_hit = claim_rd && !bus_addr[7] && sel_id != '0;

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> msip == '0);

  a_r9_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> bus_rvalid);

  a_r9_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !bus_rvalid);

  a_r6_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
    claim_hit |=> !pend[$past(sel_id)]);

  a_r7_empty_claim_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_rd && sel_id == '0) |=> ($stable(pend) && $stable(clm_flat)));

  a_r8_claims_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !cmp_hit) |=> $stable(clm_flat));

  a_r3_pend_only_grows: assert property (@(posedge clk) disable iff (!rst_n)
    !claim_hit |=> ((pend & $past(pend)) == $past(pend)));
endmodule

// File: tb/sim_ipi_claim_ctrl.sv
module sim_ipi_claim_ctrl;
  localparam int NHART = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic [NHART-1:0] msip;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ipi_claim_ctrl #(.NHART(NHART), .PW(3)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .msip(msip));

  localparam logic [9:0] PEND = 10'h100;
  function automatic logic [9:0] a_prio(int id); return 10'(4 * id); endfunction
  function automatic logic [9:0] a_en(int h);    return 10'(10'h200 + 4 * h); endfunction
  function automatic logic [9:0] a_clm(int h);   return 10'(10'h300 + 4 * h); endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    chk("R9 rvalid after read", 32'(bus_rvalid), 32'd1);
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 msip after reset", 32'(msip), 32'd0);
    rd(PEND, d);      chk("R1 pending after reset", d, 0);
    rd(a_prio(1), d); chk("R1 priority after reset", d, 0);
    rd(a_en(2), d);   chk("R1 enable after reset", d, 0);
    rd(a_clm(0), d);  chk("R1 claim after reset", d, 0);
    @(negedge clk);
    chk("R9 rvalid drops", 32'(bus_rvalid), 0);
  endtask

  task automatic t_id0;
    logic [31:0] d;
    wr(a_prio(0), 7);  rd(a_prio(0), d); chk("R2 id0 priority", d, 0);
    wr(PEND, 32'h1);   rd(PEND, d);      chk("R2 id0 pending", d, 0);
    wr(a_en(0), 32'hFFFF_FFFF); rd(a_en(0), d); chk("R2 R5 enable all-ones", d, 32'h1E);
    wr(a_en(0), 0);    rd(a_en(0), d);   chk("R5 enable clear", d, 0);
  endtask

  task automatic t_pend;
    logic [31:0] d;
    wr(PEND, 32'h4);  wr(PEND, 32'h10);
    rd(PEND, d); chk("R3 pending accumulates", d, 32'h14);
    wr(PEND, 0);  rd(PEND, d); chk("R3 zero write unchanged", d, 32'h14);
    wr(PEND, 32'hFFFF_FFE0); rd(PEND, d); chk("R3 high bits ignored", d, 32'h14);
  endtask

  task automatic t_prio_claim;
    logic [31:0] d;
    wr(a_en(1), 32'h14);
    @(negedge clk); chk("R4 priority zero silent", 32'(msip), 0);
    wr(a_prio(2), 1);
    @(negedge clk); chk("R4 R5 msip on hart1 only", 32'(msip), 32'b0010);
    rd(a_clm(1), d); chk("R6 claim returns id2", d, 2);
    rd(PEND, d);     chk("R6 claim cleared pending", d, 32'h10);
    chk("R4 msip low after claim", 32'(msip), 0);
    rd(a_clm(1), d); chk("R7 empty claim returns 0", d, 0);
    rd(PEND, d);     chk("R7 pending unchanged", d, 32'h10);
  endtask

  task automatic t_block;
    logic [31:0] d;
    wr(PEND, 32'h4);
    @(negedge clk); chk("R8 claimed source blocked", 32'(msip[1]), 0);
    wr(a_clm(1), 3);
    @(negedge clk); chk("R8 wrong completion ignored", 32'(msip[1]), 0);
    wr(a_clm(1), 2);
    @(negedge clk); chk("R8 completion re-presents", 32'(msip[1]), 1);
    rd(a_clm(1), d); chk("R8 reclaim id2", d, 2);
    wr(a_clm(1), 2);
  endtask

  task automatic t_order;
    logic [31:0] d;
    wr(a_prio(1), 2); wr(a_prio(2), 5); wr(a_prio(3), 5); wr(a_prio(4), 1);
    wr(a_en(0), 32'h1E);
    wr(a_en(1), 0);
    wr(PEND, 32'h1E);
    @(negedge clk); chk("R4 msip hart0", 32'(msip), 32'b0001);
    rd(a_clm(0), d); chk("R6 tie goes to id2", d, 2);
    rd(a_clm(0), d); chk("R6 next id3", d, 3);
    rd(a_clm(0), d); chk("R6 then id1", d, 1);
    rd(a_clm(0), d); chk("R6 then id4", d, 4);
    rd(a_clm(0), d); chk("R7 none left", d, 0);
    chk("R4 msip low when drained", 32'(msip), 0);
    for (int i = 1; i <= 4; i++) wr(a_clm(0), 32'(i));
    wr(a_en(3), 32'h10);
    wr(PEND, 32'h10);
    @(negedge clk); chk("R5 hart3 via id4", 32'(msip), 32'b1001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_id0();
    t_pend();
    t_prio_claim();
    t_block();
    t_order();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule